// File: doc/BRIEF.md
# Asynchronous Pseudo-SRAM Bus Controller

This block is a clocked bus master for an asynchronous, SRAM-compatible pseudo-static memory of one mebiword by sixteen bits. A client issues one word or byte-lane request at a time: read or write, a 20-bit word address, a two-bit active-high byte-enable and, for writes, sixteen bits of data. The controller turns each request into a single access on the memory pins. It drives active-low chip-select, output-enable, write-enable and a strobe for each byte lane, holds the address on the memory bus, and drives or samples the 16-bit bidirectional data bus.

Every pin interval comes from a nanosecond figure and the clock period `CLK_PERIOD_NS`, and is rounded up to whole clocks. Defaults assume a 100 MHz clock. A read holds the strobes low until the slowest access path has settled, samples the bus on the last clock, and then returns the data with a one-clock `rvalid` pulse. Writes keep output-enable high and keep driving the data for one clock after write-enable rises. After a read, all strobes stay high for a bus turnaround window before the next access. The memory refreshes itself in the background, so no access may keep chip-select low for longer than about a microsecond. The controller never stretches an access.

Top module: `psram_ctrl`

## Requirements
- R1: `ready` is high exactly when the controller is idle. A request is taken on a rising clock edge with `req` and `ready` both high. In the clock that follows, `ready` is low and the memory strobes of that access are already asserted.
- R2: A read holds `mem_cs_n` and `mem_oe_n` low and `mem_we_n` high for RD clocks, where RD = ceil(max(cycle 70 ns, access 70 ns, output-enable 25 ns) / period). The lane strobes are driven as `mem_ub_n` = not `be[1]` (bits 15..8) and `mem_lb_n` = not `be[0]` (bits 7..0). `mem_addr` stays stable for the whole access.
- R3: Every access holds `mem_cs_n` low for at least 70 ns and for at most 1000 ns.
- R4: A write holds `mem_cs_n` and `mem_we_n` low and `mem_oe_n` high for WR clocks, where WR = ceil(max(70, 50, 60, 20 ns) / period). During those clocks the controller drives `wdata` on each enabled lane. It never drives the bus while `mem_oe_n` is low.
- R5: After the write clocks, the controller spends one clock with every strobe high. In that clock it keeps the address and the write data on the enabled lanes. After that clock it releases the bus.
- R6: The clock after the last read clock, `rvalid` is high for exactly one clock. At the same time `rdata` carries the sampled data on the enabled lanes and zero on the disabled lanes.
- R7: After a read, all strobes stay high for TURN = max(1, ceil(15 ns / period)) clocks before the next access can start.
- R8: A write with only one byte-enable bit set changes only that byte lane of the addressed word.
- R9: A request with `be` = 0 runs a full-length cycle with both lane strobes high. If it is a write, memory contents stay unchanged. If it is a read, it returns zero.
- R10: During and right after reset, all strobes are high, `ready` is high, `rvalid` is low and the bus is not driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, taken when `ready` is high |
| we | input | 1 | 1 = write, 0 = read |
| be | input | 2 | Active-high byte enables, bit 1 = upper lane |
| addr | input | 20 | Word address |
| wdata | input | 16 | Write data |
| ready | output | 1 | Controller idle, request will be taken |
| rvalid | output | 1 | One-clock read-data valid pulse |
| rdata | output | 16 | Read data, disabled lanes zero |
| mem_addr | output | 20 | Memory address bus |
| mem_dq | inout | 16 | Memory data bus |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | Upper lane strobe, active low |
| mem_lb_n | output | 1 | Lower lane strobe, active low |

## Verification
The bench issues back-to-back reads and writes at the exact clock `ready` returns.
- A read followed straight by a write catches a controller that skips the turnaround: write-enable would fall within 15 ns of the read ending, while the memory may still be driving the bus.
- Single-lane writes and reads, and requests with no byte enable, expose lane strobe mapping errors: the wrong byte of the word would change, or the stale lane would come back unmasked.
- Pin-level write commits and the check of the hold clock catch a controller that drops its data as write-enable rises.
- Measuring every chip-select low window in nanoseconds catches a miscounted interval. Such a design would cut an access short of the cycle minimum or sample read data before it is valid.

// File: rtl/psram_ctrl_pkg.sv
package psram_ctrl_pkg;

    localparam int ADDR_W = 20;
    localparam int DATA_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = DATA_W / LANE_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READ,
        PH_TURN,
        PH_WRITE,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic              we;
        logic [LANES-1:0]  be;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } access_t;

    typedef struct packed {
        logic             cs_n;
        logic             oe_n;
        logic             we_n;
        logic [LANES-1:0] lane_n;
    } strobes_t;

    function automatic int clocks_for(input int ns, input int period_ns);
        return (ns + period_ns - 1) / period_ns;
    endfunction

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic strobes_t strobes_for(input phase_e ph, input logic [LANES-1:0] be);
        strobes_t s;
        s.cs_n   = 1'b1;
        s.oe_n   = 1'b1;
        s.we_n   = 1'b1;
        s.lane_n = '1;
        case (ph)
            PH_READ: begin
                s.cs_n   = 1'b0;
                s.oe_n   = 1'b0;
                s.lane_n = ~be;
            end
            PH_WRITE: begin
                s.cs_n   = 1'b0;
                s.we_n   = 1'b0;
                s.lane_n = ~be;
            end
            default: ;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/psram_interval_timer.sv
module psram_interval_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/psram_lane_io.sv
module psram_lane_io
    import psram_ctrl_pkg::*;
(
    input  logic              drive_en,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_masked,
    inout  wire  [DATA_W-1:0] dq
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign dq[g*LANE_W +: LANE_W] =
            (drive_en && lane_en[g]) ? wdata[g*LANE_W +: LANE_W] : {LANE_W{1'bz}};
        assign rd_masked[g*LANE_W +: LANE_W] =
            lane_en[g] ? dq[g*LANE_W +: LANE_W] : '0;
    end

endmodule

// File: rtl/psram_ctrl.sv
module psram_ctrl
    import psram_ctrl_pkg::*;
#(
    parameter int CLK_PERIOD_NS = 10,
    parameter int T_CYCLE_NS    = 70,
    parameter int T_ACCESS_NS   = 70,
    parameter int T_OE_NS       = 25,
    parameter int T_WP_NS       = 50,
    parameter int T_CW_NS       = 60,
    parameter int T_DW_NS       = 20,
    parameter int T_HZ_NS       = 15,
    parameter int T_MAX_NS      = 1000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic              we,
    input  logic [1:0]        be,
    input  logic [19:0]       addr,
    input  logic [15:0]       wdata,
    output logic              ready,
    output logic              rvalid,
    output logic [15:0]       rdata,
    output logic [19:0]       mem_addr,
    inout  wire  [15:0]       mem_dq,
    output logic              mem_cs_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic              mem_ub_n,
    output logic              mem_lb_n
);

    localparam int CYC_CLKS  = clocks_for(T_CYCLE_NS, CLK_PERIOD_NS);
    localparam int RD_CLKS   = max_of(CYC_CLKS,
                                      clocks_for(max_of(T_ACCESS_NS, T_OE_NS), CLK_PERIOD_NS));
    localparam int WR_CLKS   = max_of(max_of(CYC_CLKS, clocks_for(T_WP_NS, CLK_PERIOD_NS)),
                                      max_of(clocks_for(T_CW_NS, CLK_PERIOD_NS),
                                             clocks_for(T_DW_NS, CLK_PERIOD_NS)));
    localparam int TURN_CLKS = max_of(1, clocks_for(T_HZ_NS, CLK_PERIOD_NS));
    localparam int MAX_CLKS  = T_MAX_NS / CLK_PERIOD_NS;
    localparam int CNT_TOP   = max_of(RD_CLKS, max_of(WR_CLKS, TURN_CLKS));
    localparam int CNT_W     = $clog2(CNT_TOP + 1);

    phase_e            ph_q, ph_d;
    access_t           acc_q, acc_d;
    strobes_t          pins_q;
    logic              drive_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_done;
    logic              capture;
    logic              rvalid_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] rd_word;

    psram_interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    psram_lane_io u_lanes (
        .drive_en  (drive_q),
        .lane_en   (acc_q.be),
        .wdata     (acc_q.wdata),
        .rd_masked (rd_word),
        .dq        (mem_dq)
    );

    always_comb begin
        ph_d     = ph_q;
        acc_d    = acc_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (ph_q)
            PH_IDLE: begin
                if (req) begin
                    acc_d    = '{we: we, be: be, addr: addr, wdata: wdata};
                    ph_d     = we ? PH_WRITE : PH_READ;
                    tmr_load = 1'b1;
                    tmr_val  = we ? CNT_W'(WR_CLKS - 1) : CNT_W'(RD_CLKS - 1);
                end
            end
            PH_READ: begin
                if (tmr_done) begin
                    capture  = 1'b1;
                    ph_d     = PH_TURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CLKS - 1);
                end
            end
            PH_TURN: begin
                if (tmr_done) ph_d = PH_IDLE;
            end
            PH_WRITE: begin
                if (tmr_done) ph_d = PH_HOLD;
            end
            PH_HOLD: ph_d = PH_IDLE;
            default: ph_d = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_IDLE;
            acc_q    <= '0;
            pins_q   <= strobes_for(PH_IDLE, '0);
            drive_q  <= 1'b0;
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            ph_q     <= ph_d;
            acc_q    <= acc_d;
            pins_q   <= strobes_for(ph_d, acc_d.be);
            drive_q  <= (ph_d == PH_WRITE) || (ph_d == PH_HOLD);
            rvalid_q <= capture;
            if (capture) rdata_q <= rd_word;
        end
    end

    assign ready    = (ph_q == PH_IDLE);
    assign rvalid   = rvalid_q;
    assign rdata    = rdata_q;
    assign mem_addr = acc_q.addr;
    assign mem_cs_n = pins_q.cs_n;
    assign mem_oe_n = pins_q.oe_n;
    assign mem_we_n = pins_q.we_n;
    assign mem_ub_n = pins_q.lane_n[1];
    assign mem_lb_n = pins_q.lane_n[0];

endmodule

// File: rtl/psram_ctrl_chk.sv
module psram_ctrl_chk #(
    parameter int MIN_CLKS  = 7,
    parameter int MAX_CLKS  = 100,
    parameter int TURN_CLKS = 2
) (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic        ready,
    input logic        rvalid,
    input logic [19:0] mem_addr,
    input logic        mem_cs_n,
    input logic        mem_oe_n,
    input logic        mem_we_n,
    input logic        drive_en
);

    int unsigned lo_cnt;
    int unsigned hi_cnt;
    logic        last_read;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt    <= 0;
            hi_cnt    <= 0;
            last_read <= 1'b0;
        end else begin
            if (mem_cs_n) begin
                lo_cnt <= 0;
                if (hi_cnt < 1000) hi_cnt <= hi_cnt + 1;
            end else begin
                lo_cnt    <= lo_cnt + 1;
                hi_cnt    <= 0;
                last_read <= !mem_oe_n;
            end
        end
    end

    a_r1_accept_starts: assert property (@(posedge clk) disable iff (rst)
        (req && ready) |=> (!ready && !mem_cs_n));

    a_r2_addr_stable: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

    a_r3_min_cycle: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_cs_n) |-> (lo_cnt >= MIN_CLKS));

    a_r3_max_cycle: assert property (@(posedge clk) disable iff (rst)
        !mem_cs_n |-> (lo_cnt < MAX_CLKS));

    a_r4_write_oe_high: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> (!mem_cs_n && mem_oe_n));

    a_r4_no_drive_on_read: assert property (@(posedge clk) disable iff (rst)
        drive_en |-> mem_oe_n);

    a_r5_data_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> drive_en);

    a_r6_rvalid_pulse: assert property (@(posedge clk) disable iff (rst)
        rvalid |=> !rvalid);

    a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
        ($fell(mem_cs_n) && last_read) |-> (hi_cnt >= TURN_CLKS));

endmodule

bind psram_ctrl psram_ctrl_chk #(
    .MIN_CLKS  (CYC_CLKS),
    .MAX_CLKS  (MAX_CLKS),
    .TURN_CLKS (TURN_CLKS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req      (req),
    .ready    (ready),
    .rvalid   (rvalid),
    .mem_addr (mem_addr),
    .mem_cs_n (mem_cs_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .drive_en (drive_q)
);

// File: tb/psram_ctrl_tb_top.sv
module psram_ctrl_tb_top;

    localparam int P    = 8;
    localparam int RD   = ((70 + P - 1) / P);
    localparam int WR   = ((70 + P - 1) / P);
    localparam int TURN = ((15 + P - 1) / P) > 1 ? ((15 + P - 1) / P) : 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic        we = 1'b0;
    logic [1:0]  be = 2'b00;
    logic [19:0] addr = '0;
    logic [15:0] wdata = '0;
    logic        ready, rvalid;
    logic [15:0] rdata;
    logic [19:0] mem_addr;
    wire  [15:0] mem_dq;
    logic        mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;

    int checks = 0;
    int errors = 0;
    bit run_chk = 1'b0;

    always #(P/2) clk = ~clk;

    psram_ctrl #(.CLK_PERIOD_NS(P)) dut_i (
        .clk(clk), .rst(rst), .req(req), .we(we), .be(be), .addr(addr),
        .wdata(wdata), .ready(ready), .rvalid(rvalid), .rdata(rdata),
        .mem_addr(mem_addr), .mem_dq(mem_dq), .mem_cs_n(mem_cs_n),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n),
        .mem_lb_n(mem_lb_n)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // ---------------- pin-level memory model ----------------
    logic [15:0] pmem [int];
    logic [15:0] mem_word;
    bit          pend = 1'b0;
    logic [19:0] p_addr;
    logic [15:0] p_data;
    logic [1:0]  p_be;

    always @* begin
        mem_word = pmem.exists(int'(mem_addr)) ? pmem[int'(mem_addr)] : 16'h0000;
    end

    assign mem_dq[7:0]  = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_lb_n) ? mem_word[7:0]  : 8'bz;
    assign mem_dq[15:8] = (!mem_cs_n && !mem_oe_n && mem_we_n && !mem_ub_n) ? mem_word[15:8] : 8'bz;

    always @(negedge clk) begin
        if (!rst) begin
            if (!mem_cs_n && !mem_we_n) begin
                pend   = 1'b1;
                p_addr = mem_addr;
                p_be   = {!mem_ub_n, !mem_lb_n};
                p_data = mem_dq;
            end else if (pend) begin
                logic [15:0] w;
                w = pmem.exists(int'(p_addr)) ? pmem[int'(p_addr)] : 16'h0000;
                if (p_be[0]) w[7:0]  = p_data[7:0];
                if (p_be[1]) w[15:8] = p_data[15:8];
                pmem[int'(p_addr)] = w;
                pend = 1'b0;
            end
        end
    end

    // ---------------- reference model: queue of expected pin states ----------------
    typedef struct {
        bit          rdy;
        bit          cs_n, oe_n, we_n, ub_n, lb_n;
        bit          chk_addr;
        logic [19:0] addr;
        bit          rv;
        logic [15:0] rd;
        bit          drv;
        logic [15:0] wd;
        logic [1:0]  be;
        string       tag;
    } exp_t;

    exp_t        q [$];
    exp_t        cur;
    logic [15:0] ref_mem [int];

    function automatic exp_t idle_e();
        exp_t e;
        e.rdy = 1; e.cs_n = 1; e.oe_n = 1; e.we_n = 1; e.ub_n = 1; e.lb_n = 1;
        e.chk_addr = 0; e.addr = '0; e.rv = 0; e.rd = '0; e.drv = 0; e.wd = '0;
        e.be = '0; e.tag = "R1";
        return e;
    endfunction

    function automatic logic [15:0] ref_rd(input logic [19:0] a);
        return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : 16'h0000;
    endfunction

    task automatic push_access(input bit w, input logic [1:0] b, input logic [19:0] a,
                               input logic [15:0] d);
        exp_t e;
        logic [15:0] m;
        e = idle_e();
        e.rdy = 0; e.cs_n = 0; e.ub_n = !b[1]; e.lb_n = !b[0];
        e.chk_addr = 1; e.addr = a; e.be = b;
        e.tag = (b == 2'b00) ? "R9" : (w ? "R4" : "R2");
        if (w) begin
            e.we_n = 0; e.drv = 1; e.wd = d;
            for (int i = 0; i < WR; i++) q.push_back(e);
            e.cs_n = 1; e.we_n = 1; e.ub_n = 1; e.lb_n = 1; e.tag = "R5";
            q.push_back(e);
            m = ref_rd(a);
            if (b[0]) m[7:0]  = d[7:0];
            if (b[1]) m[15:8] = d[15:8];
            ref_mem[int'(a)] = m;
        end else begin
            e.oe_n = 0;
            for (int i = 0; i < RD; i++) q.push_back(e);
            m = ref_rd(a);
            e = idle_e();
            e.rdy = 0; e.tag = "R7";
            for (int i = 0; i < TURN; i++) begin
                e.rv = (i == 0);
                e.rd = {b[1] ? m[15:8] : 8'h00, b[0] ? m[7:0] : 8'h00};
                q.push_back(e);
            end
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
            cur = idle_e();
        end else begin
            if (req && cur.rdy) push_access(we, be, addr, wdata);
            if (q.size() > 0) cur = q.pop_front();
            else cur = idle_e();
        end
    end

    always @(negedge clk) begin
        if (!rst && run_chk) begin
            check(ready === cur.rdy, "R1", "ready", 32'(ready), 32'(cur.rdy));
            check({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} ===
                  {cur.cs_n, cur.oe_n, cur.we_n, cur.ub_n, cur.lb_n}, cur.tag, "strobes cs/oe/we/ub/lb",
                  32'({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}),
                  32'({cur.cs_n, cur.oe_n, cur.we_n, cur.ub_n, cur.lb_n}));
            if (cur.chk_addr)
                check(mem_addr === cur.addr, cur.tag, "mem_addr", 32'(mem_addr), 32'(cur.addr));
            check(rvalid === cur.rv, "R6", "rvalid", 32'(rvalid), 32'(cur.rv));
            if (cur.rv)
                check(rdata === cur.rd, "R6", "rdata", 32'(rdata), 32'(cur.rd));
            if (cur.drv) begin
                if (cur.be[0])
                    check(mem_dq[7:0] === cur.wd[7:0], cur.tag, "dq low lane", 32'(mem_dq[7:0]), 32'(cur.wd[7:0]));
                if (cur.be[1])
                    check(mem_dq[15:8] === cur.wd[15:8], cur.tag, "dq high lane", 32'(mem_dq[15:8]), 32'(cur.wd[15:8]));
            end
        end
    end

    // ---------------- nanosecond timing checker ----------------
    realtime t_fall = 0.0;
    realtime t_rd_end = -1000.0;
    bit      prev_read = 1'b0;

    always @(negedge clk) begin
        if (!rst && !mem_cs_n) prev_read = !mem_oe_n;
    end

    always @(negedge mem_cs_n) t_fall = $realtime;

    always @(posedge mem_cs_n) begin
        if (!rst && run_chk) begin
            realtime w;
            w = $realtime - t_fall;
            check(w >= 70.0 && w <= 1000.0, "R3", "cs low ns", 32'(int'(w)), 32'd70);
            if (prev_read) t_rd_end = $realtime;
        end
    end

    always @(negedge mem_we_n) begin
        if (!rst && run_chk && prev_read) begin
            check(($realtime - t_rd_end) >= 15.0, "R7", "read end to write ns",
                  32'(int'($realtime - t_rd_end)), 32'd15);
        end
    end

    // ---------------- stimulus ----------------
    task automatic op(input bit w, input logic [1:0] b, input logic [19:0] a,
                      input logic [15:0] d);
        @(negedge clk);
        while (!ready) @(negedge clk);
        req = 1'b1; we = w; be = b; addr = a; wdata = d;
        @(negedge clk);
        req = 1'b0; we = 1'b0; be = 2'b00; wdata = 16'hDEAD;
    endtask

    task automatic drain();
        repeat (RD + WR + TURN + 4) @(negedge clk);
    endtask

    initial begin : main
        logic [31:0] lfsr;
        repeat (3) @(negedge clk);
        // R10: reset state
        check(ready === 1'b1 && rvalid === 1'b0, "R10", "ready/rvalid in reset",
              32'({ready, rvalid}), 32'b10);
        check({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n} === 5'b11111, "R10",
              "strobes in reset", 32'({mem_cs_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n}), 32'h1f);
        @(posedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(ready === 1'b1 && {mem_cs_n, mem_we_n} === 2'b11, "R10", "idle after reset",
              32'({ready, mem_cs_n, mem_we_n}), 32'b111);
        run_chk = 1'b1;

        // R4/R2: word write then read
        op(1, 2'b11, 20'h00001, 16'hA5C3);
        op(0, 2'b11, 20'h00001, 16'h0000);
        // R8: single-lane writes
        op(1, 2'b10, 20'h00001, 16'h12FF);
        op(0, 2'b11, 20'h00001, 16'h0000);
        op(1, 2'b01, 20'h00001, 16'hEE34);
        op(0, 2'b11, 20'h00001, 16'h0000);
        // R9: no byte enable
        op(1, 2'b00, 20'h00001, 16'h5555);
        op(0, 2'b11, 20'h00001, 16'h0000);
        op(0, 2'b00, 20'h00001, 16'h0000);
        // R6: lane-masked reads
        op(0, 2'b01, 20'h00001, 16'h0000);
        op(0, 2'b10, 20'h00001, 16'h0000);
        // address corners, read immediately followed by write (R7)
        op(1, 2'b11, 20'hFFFFF, 16'hBEEF);
        op(1, 2'b11, 20'h00000, 16'h0F0F);
        op(0, 2'b11, 20'hFFFFF, 16'h0000);
        op(1, 2'b11, 20'h80000, 16'h7E81);
        op(0, 2'b11, 20'h00000, 16'h0000);
        op(0, 2'b11, 20'h80000, 16'h0000);

        // mixed pattern
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 48; i++) begin
            logic [19:0] a;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            a = {lfsr[7:6], 15'h0, lfsr[10:8]};
            op(lfsr[3], lfsr[5:4], a, lfsr[31:16]);
        end

        drain();
        check(ready === 1'b1 && mem_cs_n === 1'b1, "R1", "idle at end",
              32'({ready, mem_cs_n}), 32'b11);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        #(P * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule